// File: doc/BRIEF.md
# Aperture Address Detiler

This block sits in the path of a linear aperture. A set of programmable range entries each marks a window of the aperture as one tiled surface. Every request address is compared with all enabled entries. When an entry claims it, the address is treated as a pitch-major (row, column) position inside that surface and is rewritten into the byte address the tiled memory layout uses, for either X or Y tiling. Addresses that no entry claims leave unchanged.

Each entry is 64 bits wide and is loaded through a 32-bit write port, one half at a time. The enable bit sits in the low half. Software first clears the low half, then loads the high half, then loads the low half with the enable bit set. As an extra guard, the hardware drops the enable bit whenever the high half is written. An entry whose upper bound has just changed therefore cannot match until its low half is written again.

The translated address and a hit flag come out of one registered stage. Each request gets exactly one response, one cycle later.

Top module: `aperture_detiler`

## Requirements
- R1: A write with `reg_hi`=0 loads entry `reg_idx` with: bit 0 = enable, bits 2:1 = tiling mode (01 X, 10 Y, 00 and 11 untiled), bits 11:3 = pitch code (stride/128 − 1), bits 31:12 = first 4 KiB page. A write with `reg_hi`=1 loads bits 31:12 as the last page, which is inclusive. Bits 11:0 of the high half are ignored.
- R2: A high-half write clears the enable bit of that entry. The entry stays disabled until its low half is written with bit 0 set.
- R3: An entry is a candidate when it is enabled, its mode is X or Y, and the request page lies between its first and last pages. When several entries are candidates, the lowest-numbered one is used.
- R4: For X tiling, let offset = addr − start, row = offset / stride and col = offset mod stride. The result is start + (row & ~7)·stride + (col/512)·4096 + (row mod 8)·512 + (col mod 512).
- R5: For Y tiling, with the same row and col, the result is start + (row & ~31)·stride + (col/128)·4096 + ((col mod 128)/16)·512 + (row mod 32)·16 + (col mod 16).
- R6: Only whole bands of tile rows are usable: stride·8 bytes for X, stride·32 bytes for Y. An address in the partial band at the tail of the selected entry is a miss.
- R7: On a miss, including entries with untiled modes, `rsp_hit` is 0 and `rsp_addr` equals the request address.
- R8: `rsp_valid` follows `req_valid` one cycle later. A request in the same cycle as a register write is translated with the entry contents from before that write.
- R9: Synchronous reset disables all entries and clears `rsp_valid` and `rsp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_hi | input | 1 | Half select: 1 = high half, 0 = low half |
| reg_idx | input | IDX_W (4) | Entry number |
| reg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Linear aperture address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Address was translated |
| rsp_addr | output | 32 | Translated address, or the request address on a miss |

## Verification
A register write and a translation request can arrive in the same cycle on the same entry. The bench provokes this by presenting a request inside entry 0 on the same clock edge as a write that clears entry 0's low half. The response must still carry entry 0's X-tiled result. The next request to the same address must then fall through to the overlapping Y entry 3.

// File: rtl/detiler_pkg.sv
package detiler_pkg;
  localparam int AW      = 32;
  localparam int PG_LSB  = 12;
  localparam int PG_W    = AW - PG_LSB;
  localparam int PITCH_W = 9;

  typedef enum logic [1:0] {
    TM_NONE = 2'b00,
    TM_X    = 2'b01,
    TM_Y    = 2'b10,
    TM_RSVD = 2'b11
  } tmode_e;

  typedef struct packed {
    logic               valid;
    tmode_e             mode;
    logic [PITCH_W-1:0] pitch;
    logic [PG_W-1:0]    start_pg;
    logic [PG_W-1:0]    end_pg;
  } entry_t;
endpackage

// File: rtl/dt_entry_bank.sv
module dt_entry_bank import detiler_pkg::*; #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic                        hi,
  input  logic [IDX_W-1:0]            idx,
  input  logic [AW-1:0]               wdata,
  output entry_t [N_ENTRIES-1:0]      ents
);
  entry_t [N_ENTRIES-1:0] ents_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ents_q <= '0;
    end else if (wr) begin
      if (hi) begin
        ents_q[idx].end_pg <= wdata[AW-1:PG_LSB];
        ents_q[idx].valid  <= 1'b0;
      end else begin
        ents_q[idx].valid    <= wdata[0];
        ents_q[idx].mode     <= tmode_e'(wdata[2:1]);
        ents_q[idx].pitch    <= wdata[3 +: PITCH_W];
        ents_q[idx].start_pg <= wdata[AW-1:PG_LSB];
      end
    end
  end

  assign ents = ents_q;
endmodule

// File: rtl/dt_match.sv
module dt_match import detiler_pkg::*; #(
  parameter int N_ENTRIES = 16
) (
  input  logic [AW-1:0]           addr,
  input  entry_t [N_ENTRIES-1:0]  ents,
  output logic                    hit,
  output entry_t                  sel
);
  logic [N_ENTRIES-1:0] cand;
  logic [PG_W-1:0]      pg;
  logic                 unused_low;

  assign pg         = addr[AW-1:PG_LSB];
  assign unused_low = ^addr[PG_LSB-1:0];

  for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_cmp
    assign cand[gi] = ents[gi].valid
                   && (ents[gi].mode == TM_X || ents[gi].mode == TM_Y)
                   && (pg >= ents[gi].start_pg)
                   && (pg <= ents[gi].end_pg);
  end

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        sel = ents[i];
      end
    end
  end
endmodule

// File: rtl/dt_xlate.sv
module dt_xlate import detiler_pkg::*; (
  input  logic [AW-1:0] addr,
  input  entry_t        ent,
  output logic          band_ok,
  output logic [AW-1:0] xaddr
);
  localparam int OW = AW - 7;
  localparam int WW = AW + PITCH_W + 8;

  logic [AW-1:0]      base, offs;
  logic [PITCH_W:0]   su;
  logic [OW-1:0]      off7, su_w, row, cblk, rowband, tilex, th;
  logic [PITCH_W-1:0] cb;
  logic               is_y;
  logic [11:0]        inner;
  logic [WW-1:0]      size_units, band_end, tiled;
  logic               unused_x;

  always_comb begin
    base       = {ent.start_pg, {PG_LSB{1'b0}}};
    offs       = addr - base;
    off7       = offs[AW-1:7];
    su         = {1'b0, ent.pitch} + 1'b1;
    su_w       = OW'(su);
    row        = off7 / su_w;
    cblk       = off7 % su_w;
    cb         = cblk[PITCH_W-1:0];
    is_y       = (ent.mode == TM_Y);
    th         = is_y ? OW'(32) : OW'(8);
    rowband    = row & ~(th - OW'(1));
    size_units = (WW'(ent.end_pg - ent.start_pg) + WW'(1)) << (PG_LSB - 7);
    band_end   = (WW'(rowband) + WW'(th)) * WW'(su);
    band_ok    = (band_end <= size_units);
    if (is_y) begin
      tilex = OW'(cb);
      inner = {offs[6:4], row[4:0], offs[3:0]};
    end else begin
      tilex = OW'(cb >> 2);
      inner = {row[2:0], cb[1:0], offs[6:0]};
    end
    tiled = WW'(rowband) * WW'(su) * WW'(128) + (WW'(tilex) << 12) + WW'(inner);
    xaddr = base + tiled[AW-1:0];
  end

  assign unused_x = ^{cblk[OW-1:PITCH_W], tiled[WW-1:AW]};
endmodule

// File: rtl/aperture_detiler.sv
module aperture_detiler import detiler_pkg::*; #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_hi,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [AW-1:0]    reg_wdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [AW-1:0]    rsp_addr
);
  entry_t [N_ENTRIES-1:0] ents;
  entry_t                 sel;
  logic                   m_hit, band_ok, take;
  logic [AW-1:0]          xaddr;
  logic [N_ENTRIES-1:0]   ent_valid;

  dt_entry_bank #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr(reg_wr), .hi(reg_hi),
    .idx(reg_idx), .wdata(reg_wdata), .ents(ents)
  );

  dt_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .addr(req_addr), .ents(ents), .hit(m_hit), .sel(sel)
  );

  dt_xlate u_xlate (
    .addr(req_addr), .ent(sel), .band_ok(band_ok), .xaddr(xaddr)
  );

  for (genvar gv = 0; gv < N_ENTRIES; gv++) begin : g_vld
    assign ent_valid[gv] = ents[gv].valid;
  end

  assign take = m_hit && band_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && take;
      rsp_addr  <= take ? xaddr : req_addr;
    end
  end
endmodule

// File: rtl/aperture_detiler_chk.sv
module aperture_detiler_chk import detiler_pkg::*; #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr,
  input logic                 reg_hi,
  input logic [IDX_W-1:0]     reg_idx,
  input logic                 req_valid,
  input logic [AW-1:0]        req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [AW-1:0]        rsp_addr,
  input logic [N_ENTRIES-1:0] ent_valid
);
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_hit_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  assert_miss_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr)));
  // X and Y layouts both keep the low 16-byte offset (R5 as well)
  assert_hit_keeps_nibble_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_addr[3:0] == $past(req_addr[3:0])));
  assert_hi_write_disables_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_hi) |=> !ent_valid[$past(reg_idx)]);
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (ent_valid == '0) && !rsp_valid && !rsp_hit);
endmodule

bind aperture_detiler aperture_detiler_chk #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_hi(reg_hi), .reg_idx(reg_idx),
  .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .ent_valid(ent_valid)
);

// File: tb/aperture_detiler_tb.sv
module aperture_detiler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_hi = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  aperture_detiler u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_hi(reg_hi), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wreg(input int idx, input logic hi, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_hi = hi; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic load_entry(input int idx, input logic [31:0] s, input logic [31:0] e,
                            input logic [8:0] pitch, input logic [1:0] mode);
    wreg(idx, 1'b0, 32'h0);
    wreg(idx, 1'b1, {e[31:12], 12'h0});
    wreg(idx, 1'b0, {s[31:12], pitch, mode, 1'b1});
  endtask

  task automatic xl(input string tag, input logic [31:0] a,
                    input logic exp_hit, input logic [31:0] exp_addr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit"},   32'(rsp_hit),   32'(exp_hit));
    check({tag, " addr"},  rsp_addr,       exp_addr);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 rsp_valid idle", 32'(rsp_valid), 32'd0);
    xl("R9 empty bank", 32'h0010_0000, 1'b0, 32'h0010_0000);
  endtask

  task automatic t_xtile;
    load_entry(0, 32'h0010_0000, 32'h0010_F000, 9'd7, 2'b01);
    xl("R4 origin",     32'h0010_0000, 1'b1, 32'h0010_0000);
    xl("R4 col5",       32'h0010_0005, 1'b1, 32'h0010_0005);
    xl("R4 row1",       32'h0010_0400, 1'b1, 32'h0010_0200);
    xl("R4 row9 col600", 32'h0010_2658, 1'b1, 32'h0010_3258);
    xl("R4 last byte",  32'h0010_FFFF, 1'b1, 32'h0010_FFFF);
    xl("R7 past end",   32'h0011_0000, 1'b0, 32'h0011_0000);
  endtask

  task automatic t_ytile;
    load_entry(1, 32'h0020_0000, 32'h0020_2000, 9'd1, 2'b10);
    xl("R5 row3 col200", 32'h0020_03C8, 1'b1, 32'h0020_1838);
    xl("R6 tail band",   32'h0020_2010, 1'b0, 32'h0020_2010);
  endtask

  task automatic t_untiled;
    load_entry(5, 32'h0030_0000, 32'h0030_0000, 9'd3, 2'b00);
    load_entry(7, 32'h0050_0000, 32'h0050_0000, 9'd3, 2'b11);
    xl("R7 mode00", 32'h0030_0100, 1'b0, 32'h0030_0100);
    xl("R7 mode11", 32'h0050_0100, 1'b0, 32'h0050_0100);
  endtask

  task automatic t_priority_and_race;
    load_entry(3, 32'h0010_0000, 32'h0010_F000, 9'd7, 2'b10);
    xl("R3 lowest wins", 32'h0010_2658, 1'b1, 32'h0010_3258);
    // request and clearing write on the same edge
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0010_2658;
    reg_wr = 1'b1; reg_hi = 1'b0; reg_idx = 4'd0; reg_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0;
    check("R8 same-cycle hit",  32'(rsp_hit), 32'd1);
    check("R8 same-cycle addr", rsp_addr, 32'h0010_3258);
    xl("R3 fallthrough to 3", 32'h0010_2658, 1'b1, 32'h0010_4A98);
  endtask

  task automatic t_guard;
    load_entry(6, 32'h0040_0000, 32'h0040_1000, 9'd3, 2'b01);
    xl("R1 loaded",        32'h0040_0210, 1'b1, 32'h0040_0210);
    wreg(6, 1'b1, 32'h0040_0000);
    xl("R2 hi write off",  32'h0040_0210, 1'b0, 32'h0040_0210);
    wreg(6, 1'b0, {20'h00400, 9'd3, 2'b01, 1'b1});
    xl("R1 re-enabled",    32'h0040_0210, 1'b1, 32'h0040_0210);
    xl("R1 new end page",  32'h0040_1010, 1'b0, 32'h0040_1010);
  endtask

  initial begin
    t_reset();
    t_xtile();
    t_ytile();
    t_untiled();
    t_priority_and_race();
    t_guard();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule